// File: doc/BRIEF.md
# Short-Sync PCM Serial Port

This block is a single-channel serial transceiver for 8-bit PCM samples. An external bit clock and a frame-sync input frame each sample. Both are sampled in the system clock domain, and their rising and falling edges are found as events. A frame begins when frame sync is seen high at a falling bit-clock edge. From that point the block shifts out a parallel transmit word, most significant bit first, on the following rising edges. It assembles a receive word from the following falling edges.

The transmit pin is modelled as a data bit plus an output enable. The enable goes high together with the first bit. It drops half a bit period into the last bit, on the falling edge in the middle of that bit. The block measures the width of every sync pulse and uses it to classify the next frame. A pulse that spans exactly one falling edge makes the next frame short-sync, and only short-sync frames move data. After any power-down, the transmitter keeps its enable low for the next two frames so that it cannot collide with another driver on the bus.

Top module: `pcm_sync_port`

## Requirements
- R1: After reset, txEn, rxValid and syncLong are 0 and rxWord is 8'h00.
- R2: A frame starts at a falling bit-clock edge where frameSync is 1 and frameSync was 0 at the previous falling edge. txWord is captured at that edge, and txEn is 0 before the first data bit.
- R3: On the k-th rising edge after the frame start (k = 1..8), txData carries bit 8-k of the captured word, so bit 7 goes first. txEn rises together with the first bit and stays 1 through the remaining bits.
- R4: txEn returns to 0 at the eighth falling edge after the frame start, which is the middle of the last bit.
- R5: rxData is sampled on the first through eighth falling edges after the frame start, and the first sample lands in bit 7 of the word. After the eighth sample, rxWord takes the new word and rxValid is 1 for exactly one system clock. rxWord changes at no other time.
- R6: A frame is short-sync when the previous sync pulse was high for exactly one falling edge, and long-sync otherwise. The first frame after reset is short-sync. During a long-sync frame, syncLong is 1, txEn stays 0 and no rxValid is produced. syncLong is 0 during a short-sync frame.
- R7: While powerDown is 1, txEn is 0 one clock later, any frame in progress is abandoned and no rxValid is produced.
- R8: In the two frames that start after powerDown returns to 0, txEn stays 0 while reception still completes normally. The third frame drives txEn again.
- R9: When the next sync arrives on the eighth falling edge, one edge releases txEn, completes the receive word and starts the next frame. The next frame then runs normally.
- R10: txEn is 0 whenever no short-sync frame is transmitting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitClk | input | 1 | Serial bit clock, sampled by clk |
| frameSync | input | 1 | Frame sync pulse |
| powerDown | input | 1 | Power-down request, active high |
| txWord | input | 8 | Sample to transmit, captured at frame start |
| txData | output | 1 | Serial transmit bit |
| txEn | output | 1 | Transmit output enable (low means high impedance) |
| rxData | input | 1 | Serial receive bit |
| rxWord | output | 8 | Last received sample |
| rxValid | output | 1 | One-clock strobe when rxWord updates |
| syncLong | output | 1 | Current frame was classified as long-sync |

## Verification
Three functions can fall on the same falling bit-clock edge. The release of the transmit enable in the middle of the last bit and the capture of the eighth receive bit share that edge, and the start of the next frame can share it too. The bench provokes this by raising frame sync during the eighth bit, so that the sync is seen on the falling edge that ends the frame. It then checks that txEn is low after that edge, that the completed receive word is correct, and that the following frame transmits its own word from the first bit on.

// File: rtl/pcm_sync_pkg.sv
package pcm_sync_pkg;
  // Strobes from the control unit to the datapath, valid for one clk.
  typedef struct packed {
    logic loadTx;  // capture the parallel transmit word
    logic txBit;   // present the next transmit bit
    logic enSet;   // raise the output enable
    logic enClr;   // drop the output enable (wins over enSet)
    logic rxBit;   // shift in one receive bit
    logic rxDone;  // last receive bit: publish the word
  } dpStrobe_t;
endpackage

// File: rtl/pcm_sync_ctrl.sv
module pcm_sync_ctrl
  import pcm_sync_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int BLANK_FRAMES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitClk,
  input  logic      frameSync,
  input  logic      powerDown,
  output dpStrobe_t strobe,
  output logic      syncLong
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam int BLK_W = $clog2(BLANK_FRAMES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] PENULT_CNT = CNT_W'(WORD_W - 1);
  localparam logic [BLK_W-1:0] BLANK_INIT = BLK_W'(BLANK_FRAMES);

  logic bcQ, bcPrev, fsQ;
  logic riseEv, fallEv;
  logic [1:0] fsRun;
  logic prevShort;
  logic active;
  logic frameBlank;
  logic [CNT_W-1:0] txCnt, rxCnt;
  logic [BLK_W-1:0] blankCnt;
  logic frameStart, runShort;

  assign riseEv = bcQ & ~bcPrev;
  assign fallEv = bcPrev & ~bcQ;
  assign frameStart = fallEv & fsQ & (fsRun == 2'd0) & ~powerDown;
  assign runShort = active & ~syncLong & ~powerDown;

  always_comb begin
    strobe = '0;
    if (powerDown) begin
      strobe.enClr = 1'b1;
    end else begin
      if (riseEv && runShort && (txCnt < LAST_CNT)) begin
        strobe.txBit = 1'b1;
        if ((txCnt == '0) && !frameBlank) strobe.enSet = 1'b1;
      end
      if (fallEv && runShort) begin
        if (txCnt == LAST_CNT) strobe.enClr = 1'b1;
        if (rxCnt < LAST_CNT) begin
          strobe.rxBit = 1'b1;
          if (rxCnt == PENULT_CNT) strobe.rxDone = 1'b1;
        end
      end
      if (frameStart) begin
        strobe.loadTx = 1'b1;
        strobe.enClr  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bcQ        <= 1'b0;
      bcPrev     <= 1'b0;
      fsQ        <= 1'b0;
      fsRun      <= 2'd0;
      prevShort  <= 1'b1;
      active     <= 1'b0;
      frameBlank <= 1'b0;
      txCnt      <= '0;
      rxCnt      <= '0;
      blankCnt   <= '0;
      syncLong   <= 1'b0;
    end else begin
      bcQ    <= bitClk;
      bcPrev <= bcQ;
      fsQ    <= frameSync;
      // sync pulse width, counted in falling edges, judges the next frame
      if (fallEv) begin
        if (fsQ) begin
          if (fsRun != 2'd3) fsRun <= fsRun + 2'd1;
        end else begin
          if (fsRun != 2'd0) prevShort <= (fsRun == 2'd1);
          fsRun <= 2'd0;
        end
      end
      if (powerDown) begin
        active   <= 1'b0;
        blankCnt <= BLANK_INIT;
      end else begin
        if (strobe.txBit) txCnt <= txCnt + 1'b1;
        if (strobe.rxBit) rxCnt <= rxCnt + 1'b1;
        if (strobe.rxDone) active <= 1'b0;
        if (frameStart) begin
          active     <= 1'b1;
          txCnt      <= '0;
          rxCnt      <= '0;
          syncLong   <= ~prevShort;
          frameBlank <= (blankCnt != '0);
          if (blankCnt != '0) blankCnt <= blankCnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_sync_dp.sv
module pcm_sync_dp
  import pcm_sync_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [WORD_W-1:0] txWord,
  input  logic              rxData,
  output logic              txData,
  output logic              txEn,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid
);
  logic [WORD_W-1:0] txShift;
  logic [WORD_W-1:0] rxShift;
  logic rxQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      txData  <= 1'b0;
      txEn    <= 1'b0;
      rxShift <= '0;
      rxQ     <= 1'b0;
      rxWord  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxQ     <= rxData;  // same sampling stage as the bit-clock edge detector
      rxValid <= strobe.rxDone;
      if (strobe.loadTx) begin
        txShift <= txWord;
      end else if (strobe.txBit) begin
        txData  <= txShift[WORD_W-1];
        txShift <= {txShift[WORD_W-2:0], 1'b0};
      end
      if (strobe.enClr) txEn <= 1'b0;
      else if (strobe.enSet) txEn <= 1'b1;
      if (strobe.rxBit) rxShift <= {rxShift[WORD_W-2:0], rxQ};
      if (strobe.rxDone) rxWord <= {rxShift[WORD_W-2:0], rxQ};
    end
  end
endmodule

// File: rtl/pcm_sync_port.sv
module pcm_sync_port
  import pcm_sync_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int BLANK_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitClk,
  input  logic              frameSync,
  input  logic              powerDown,
  input  logic [WORD_W-1:0] txWord,
  output logic              txData,
  output logic              txEn,
  input  logic              rxData,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid,
  output logic              syncLong
);
  dpStrobe_t strobe;

  pcm_sync_ctrl #(.WORD_W(WORD_W), .BLANK_FRAMES(BLANK_FRAMES)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .frameSync(frameSync),
    .powerDown(powerDown), .strobe(strobe), .syncLong(syncLong)
  );

  pcm_sync_dp #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txWord(txWord),
    .rxData(rxData), .txData(txData), .txEn(txEn),
    .rxWord(rxWord), .rxValid(rxValid)
  );
endmodule

// File: rtl/pcm_sync_port_chk.sv
module pcm_sync_port_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              powerDown,
  input logic              txEn,
  input logic              rxValid,
  input logic [WORD_W-1:0] rxWord,
  input logic              syncLong
);
  AST_PD_KILLS_EN: assert property (@(posedge clk) disable iff (!rstN) powerDown |=> !txEn); // R7
  AST_PD_NO_VALID: assert property (@(posedge clk) disable iff (!rstN) powerDown |=> !rxValid); // R7
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN) rxValid |=> !rxValid); // R5
  AST_WORD_ONLY_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN) !$stable(rxWord) |-> rxValid); // R5
  AST_LONG_NO_EN: assert property (@(posedge clk) disable iff (!rstN) syncLong |-> !txEn); // R6
endmodule

bind pcm_sync_port pcm_sync_port_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .powerDown(powerDown), .txEn(txEn),
  .rxValid(rxValid), .rxWord(rxWord), .syncLong(syncLong)
);

// File: tb/pcm_sync_port_bench.sv
module pcm_sync_port_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitClk = 1'b0;
  logic frameSync = 1'b0;
  logic powerDown = 1'b0;
  logic [7:0] txWord = 8'h00;
  logic rxData = 1'b0;
  logic txData, txEn, rxValid, syncLong;
  logic [7:0] rxWord;

  int checks = 0;
  int failures = 0;
  int rxSeen = 0;
  logic [7:0] rxLast = 8'h00;

  always #10 clk = ~clk;  // 50 MHz

  pcm_sync_port u_pcm_sync_port (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .frameSync(frameSync),
    .powerDown(powerDown), .txWord(txWord), .txData(txData), .txEn(txEn),
    .rxData(rxData), .rxWord(rxWord), .rxValid(rxValid), .syncLong(syncLong)
  );

  always @(negedge clk) if (rxValid) begin
    rxSeen = rxSeen + 1;
    rxLast = rxWord;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one bit period: rising half then falling half, 4 clk each
  task automatic bitPeriod(input logic fs, input logic rx);
    bitClk = 1'b1; frameSync = fs; rxData = rx;
    waitN(4);
    bitClk = 1'b0;
    waitN(4);
  endtask

  // rxMode: 0 no check, 1 expect word rx, 2 expect no word
  task automatic runFrame(input logic [7:0] tx, input logic [7:0] rx, input logic expEn,
                          input logic doSync, input logic chain, input logic [7:0] nextTx,
                          input logic chkTx, input int rxMode);
    int seen0;
    seen0 = rxSeen;
    if (doSync) begin
      txWord = tx;
      bitPeriod(1'b1, 1'b0);
      if (chkTx) chk("R2 txEn low before first bit", txEn, 0);
    end
    for (int k = 0; k < 8; k++) begin
      bitClk = 1'b1; frameSync = chain && (k == 7); rxData = rx[7-k];
      if (chain && k == 7) txWord = nextTx;
      waitN(3);
      if (chkTx) begin
        chk("R3 txEn during bit", txEn, expEn);
        if (expEn) chk("R3 txData bit", txData, tx[7-k]);
      end
      waitN(1);
      bitClk = 1'b0;
      waitN(3);
      if (k == 7) chk("R4 txEn released mid LSB", txEn, 0);
      else if (chkTx) chk("R3 txEn held in low phase", txEn, expEn);
      waitN(1);
    end
    if (!chain) bitPeriod(1'b0, 1'b0);
    if (rxMode == 1) begin
      chk("R5 one rxValid per frame", rxSeen, seen0 + 1);
      chk("R5 rxWord MSB first", rxLast, rx);
    end else if (rxMode == 2) begin
      chk("R6 no rxValid in long frame", rxSeen, seen0);
    end
  endtask

  localparam logic [15:0] VECS [6] = '{
    16'hA53C, 16'h00FF, 16'hFF00, 16'h817E, 16'h5AC3, 16'h0180
  };

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seenPd;
    waitN(5);
    chk("R1 txEn reset", txEn, 0);
    chk("R1 rxValid reset", rxValid, 0);
    chk("R1 rxWord reset", rxWord, 8'h00);
    chk("R1 syncLong reset", syncLong, 0);
    rstN = 1'b1;
    waitN(4);

    // table of short-sync frames
    for (int i = 0; i < 6; i++) begin
      runFrame(VECS[i][15:8], VECS[i][7:0], 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1);
      chk("R6 syncLong low in short frame", syncLong, 0);
      chk("R10 txEn idle between frames", txEn, 0);
    end

    // R9 back-to-back: release, eighth rx bit and next start on one edge
    runFrame(8'h96, 8'h69, 1'b1, 1'b1, 1'b1, 8'h3B, 1'b1, 1);
    runFrame(8'h3B, 8'hE4, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1);
    chk("R9 chained frame short", syncLong, 0);

    // R6 a two-edge sync pulse makes the next frame long
    bitPeriod(1'b1, 1'b0);
    runFrame(8'h11, 8'h22, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 0);
    runFrame(8'hC6, 8'h5D, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 2);
    chk("R6 syncLong set for long frame", syncLong, 1);
    runFrame(8'h4E, 8'hB1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1);
    chk("R6 back to short", syncLong, 0);

    // R7 power-down in the middle of a frame
    txWord = 8'hF0;
    bitPeriod(1'b1, 1'b0);
    for (int k = 0; k < 3; k++) bitPeriod(1'b0, 1'b1);
    chk("R3 txEn high before power-down", txEn, 1);
    seenPd = rxSeen;
    powerDown = 1'b1;
    waitN(2);
    chk("R7 txEn dropped by power-down", txEn, 0);
    for (int k = 0; k < 6; k++) bitPeriod(1'b0, 1'b1);
    chk("R7 abandoned frame no rxValid", rxSeen, seenPd);
    chk("R7 txEn low while powered down", txEn, 0);
    powerDown = 1'b0;
    waitN(4);

    // R8 two blanked frames, then the transmitter drives again
    runFrame(8'hAA, 8'h35, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1);
    runFrame(8'h55, 8'hCA, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1);
    runFrame(8'hD2, 8'h17, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 1);
    chk("R8 third frame after power-down idle again", txEn, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule